// File: doc/BRIEF.md
# Driver Fault-Check SPI Sequencer

This block is the host side of a fault check on an eight-channel low-side output driver. The driver sits on an SPI link. One `start` pulse, with a control byte on the input, begins a run. The block opens a frame and shifts the byte out. It then closes the frame so the driver applies it. It keeps chip-enable high for a programmable settling interval, then opens a second frame that shifts the same byte again. During that second frame it captures the byte the driver returns, which reports the sensed level of every output pin.

When the second frame closes, the block compares each returned bit with the written bit and sets two flag vectors. On the wire, a 0 bit switches a channel on and a 1 bit switches it off. A channel written 0 that reads back 1 still has its pin high, so it is flagged as shorted or overloaded. A channel written 1 that reads back 0 has nothing pulling its pin up, so it is flagged as an open load. A single-cycle `done` pulse marks the moment the flags become valid.

All SPI timing comes from the system clock, in cycles set by parameters:
- the SCLK half period;
- the chip-enable lead and lag;
- the settling wait.

Top module: `drvdiag_seq`

## Requirements
- R1: A `start` accepted while idle produces exactly two chip-enable-low frames. Each frame has N_CH SCLK pulses and carries the control byte on `mosi`, most significant bit first. The driver latches `mosi` on each falling SCLK edge.
- R2: Between the end of the first frame and the start of the second, `cs_n` stays high for exactly SETTLE_CYC system cycles.
- R3: `sclk` is low whenever `cs_n` is high and in the cycles on both sides of every `cs_n` transition.
- R4: Every SCLK high phase and every low phase between pulses of a frame lasts exactly HALF_CYC cycles. `mosi` holds still throughout each high phase, up to and including the falling edge.
- R5: The first rising SCLK edge of a frame comes LEAD_CYC cycles after `cs_n` falls. `cs_n` rises HALF_CYC+LAG_CYC cycles after the last falling SCLK edge.
- R6: `miso` is sampled in the last cycle of each SCLK high phase. The N_CH bits sampled in the second frame form the returned byte, first bit into bit N_CH-1.
- R7: `short_flags[i]` is 1 exactly when control bit i is 0 and returned bit i is 1.
- R8: `open_flags[i]` is 1 exactly when control bit i is 1 and returned bit i is 0.
- R9: A channel whose returned bit equals its written bit has both flags 0.
- R10: `done` is a single-cycle pulse in the cycle the flags update, and the flags hold until the next `done`. A `start` during a run is ignored: it changes neither the byte sent nor the number of frames.
- R11: During reset, `cs_n` is 1 and `sclk`, `done`, `short_flags` and `open_flags` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, sampled while idle |
| ctrl_byte | input | N_CH | Control byte, 0 = channel on, 1 = channel off |
| cs_n | output | 1 | Chip enable to the driver, active low |
| sclk | output | 1 | Serial clock to the driver |
| mosi | output | 1 | Serial data to the driver |
| miso | input | 1 | Serial diagnostic data from the driver |
| done | output | 1 | One-cycle pulse when flags are valid |
| short_flags | output | N_CH | Per-channel short/overload result |
| open_flags | output | N_CH | Per-channel open-load result |

## Verification
The checker relies on two input assumptions:
- `rst_n` is released only between clock edges;
- `start` and `ctrl_byte` change only away from the rising clock edge.

It also assumes `miso` settles before the end of each SCLK high phase. The bench meets that with a behavioural driver model whose data output changes only at chip-enable and falling-SCLK events, so the value is stable well before the sample point. The bench drives every input on the falling system-clock edge. It sweeps all 256 control bytes under two different fault masks, each mask derived arithmetically from the byte. Some runs add an extra `start` pulse part-way through.

// File: rtl/drvdiag_pkg.sv
package drvdiag_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_HIGH,
      ST_LOW,
      ST_LAG,
      ST_SETTLE
   } seq_state_t;

   function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/drvdiag_timer.sv
module drvdiag_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/drvdiag_shifter.sv
module drvdiag_shifter #(
   parameter int N_CH = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [N_CH-1:0] load_val,
   input  logic            advance,
   input  logic            sample,
   input  logic            miso,
   output logic            mosi,
   output logic [N_CH-1:0] rx_byte
);

   logic [N_CH-1:0] tx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
      end else if (load) begin
         tx_q <= load_val;
      end else if (advance) begin
         tx_q <= {tx_q[N_CH-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_byte <= '0;
      end else if (sample) begin
         rx_byte <= {rx_byte[N_CH-2:0], miso};
      end
   end

   assign mosi = tx_q[N_CH-1];

endmodule

// File: rtl/drvdiag_classify.sv
module drvdiag_classify #(
   parameter int N_CH = 8
) (
   input  logic [N_CH-1:0] written,
   input  logic [N_CH-1:0] returned,
   output logic [N_CH-1:0] short_o,
   output logic [N_CH-1:0] open_o
);

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      // on (0) but pin high -> short; off (1) but pin low -> open
      assign short_o[i] = ~written[i] &  returned[i];
      assign open_o[i]  =  written[i] & ~returned[i];
   end

endmodule

// File: rtl/drvdiag_seq.sv
module drvdiag_seq #(
   parameter int N_CH       = 8,
   parameter int HALF_CYC   = 13,
   parameter int LEAD_CYC   = 13,
   parameter int LAG_CYC    = 13,
   parameter int SETTLE_CYC = 8000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [N_CH-1:0] ctrl_byte,
   output logic            cs_n,
   output logic            sclk,
   output logic            mosi,
   input  logic            miso,
   output logic            done,
   output logic [N_CH-1:0] short_flags,
   output logic [N_CH-1:0] open_flags
);

   import drvdiag_pkg::*;

   localparam int unsigned MAX_CYC = max_of4(HALF_CYC, LEAD_CYC, LAG_CYC, SETTLE_CYC);
   localparam int CNT_W = $clog2(MAX_CYC + 1);
   localparam int BIT_W = (N_CH > 2) ? $clog2(N_CH) : 1;
   localparam logic [CNT_W-1:0] HALF_LD   = CNT_W'(HALF_CYC - 1);
   localparam logic [CNT_W-1:0] LEAD_LD   = CNT_W'(LEAD_CYC - 1);
   localparam logic [CNT_W-1:0] LAG_LD    = CNT_W'(LAG_CYC - 1);
   localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
   localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(N_CH - 1);

   if (N_CH < 2) begin : g_bad_width
      $error("N_CH must be at least 2");
   end
   if (HALF_CYC < 1 || LEAD_CYC < 1 || LAG_CYC < 1 || SETTLE_CYC < 1) begin : g_bad_timing
      $error("all timing parameters must be at least 1 cycle");
   end
   if (HALF_CYC > 65535) begin : g_bad_half
      $error("HALF_CYC exceeds checker counter range");
   end

   seq_state_t state, nxt_state;
   logic                 cs_nxt, sclk_nxt;
   logic                 tmr_load, tmr_exp;
   logic [CNT_W-1:0]     tmr_val;
   logic                 sh_load, sh_adv, sh_sample;
   logic [N_CH-1:0]      rx_byte, ctrl_q;
   logic                 second_pass, pass_set, bit_inc, bit_clr, flag_upd, accept;
   logic [BIT_W-1:0]     bit_idx;
   logic [N_CH-1:0]      short_w, open_w;

   always_comb begin
      nxt_state = state;
      cs_nxt    = cs_n;
      sclk_nxt  = sclk;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      sh_load   = 1'b0;
      sh_adv    = 1'b0;
      sh_sample = 1'b0;
      pass_set  = 1'b0;
      bit_inc   = 1'b0;
      bit_clr   = 1'b0;
      flag_upd  = 1'b0;
      accept    = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (start) begin
               accept    = 1'b1;
               sh_load   = 1'b1;
               bit_clr   = 1'b1;
               cs_nxt    = 1'b0;
               tmr_load  = 1'b1;
               tmr_val   = LEAD_LD;
               nxt_state = ST_LEAD;
            end
         end
         ST_LEAD: begin
            if (tmr_exp) begin
               sclk_nxt  = 1'b1;
               tmr_load  = 1'b1;
               tmr_val   = HALF_LD;
               nxt_state = ST_HIGH;
            end
         end
         ST_HIGH: begin
            if (tmr_exp) begin
               sh_sample = 1'b1;
               sclk_nxt  = 1'b0;
               tmr_load  = 1'b1;
               tmr_val   = HALF_LD;
               nxt_state = ST_LOW;
            end
         end
         ST_LOW: begin
            if (tmr_exp) begin
               tmr_load = 1'b1;
               if (bit_idx == LAST_BIT) begin
                  tmr_val   = LAG_LD;
                  nxt_state = ST_LAG;
               end else begin
                  sh_adv    = 1'b1;
                  bit_inc   = 1'b1;
                  sclk_nxt  = 1'b1;
                  tmr_val   = HALF_LD;
                  nxt_state = ST_HIGH;
               end
            end
         end
         ST_LAG: begin
            if (tmr_exp) begin
               cs_nxt = 1'b1;
               if (!second_pass) begin
                  tmr_load  = 1'b1;
                  tmr_val   = SETTLE_LD;
                  nxt_state = ST_SETTLE;
               end else begin
                  flag_upd  = 1'b1;
                  nxt_state = ST_IDLE;
               end
            end
         end
         ST_SETTLE: begin
            if (tmr_exp) begin
               cs_nxt    = 1'b0;
               sh_load   = 1'b1;
               bit_clr   = 1'b1;
               pass_set  = 1'b1;
               tmr_load  = 1'b1;
               tmr_val   = LEAD_LD;
               nxt_state = ST_LEAD;
            end
         end
         default: nxt_state = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cs_n        <= 1'b1;
         sclk        <= 1'b0;
         second_pass <= 1'b0;
         bit_idx     <= '0;
         ctrl_q      <= '0;
         done        <= 1'b0;
         short_flags <= '0;
         open_flags  <= '0;
      end else begin
         state <= nxt_state;
         cs_n  <= cs_nxt;
         sclk  <= sclk_nxt;
         done  <= flag_upd;
         if (accept) begin
            ctrl_q      <= ctrl_byte;
            second_pass <= 1'b0;
         end else if (pass_set) begin
            second_pass <= 1'b1;
         end
         if (bit_clr) begin
            bit_idx <= '0;
         end else if (bit_inc) begin
            bit_idx <= bit_idx + 1'b1;
         end
         if (flag_upd) begin
            short_flags <= short_w;
            open_flags  <= open_w;
         end
      end
   end

   drvdiag_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   drvdiag_shifter #(.N_CH(N_CH)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .load_val ((state == ST_IDLE) ? ctrl_byte : ctrl_q),
      .advance  (sh_adv),
      .sample   (sh_sample),
      .miso     (miso),
      .mosi     (mosi),
      .rx_byte  (rx_byte)
   );

   drvdiag_classify #(.N_CH(N_CH)) u_class (
      .written  (ctrl_q),
      .returned (rx_byte),
      .short_o  (short_w),
      .open_o   (open_w)
   );

endmodule

// File: rtl/drvdiag_chk.sv
module drvdiag_chk #(
   parameter int N_CH     = 8,
   parameter int HALF_CYC = 13
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cs_n,
   input logic            sclk,
   input logic            mosi,
   input logic            done,
   input logic [N_CH-1:0] short_flags,
   input logic [N_CH-1:0] open_flags
);

   logic [15:0] hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run <= '0;
      end else if (sclk) begin
         hi_run <= hi_run + 1'b1;
      end else begin
         hi_run <= '0;
      end
   end

   // R3
   sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R3
   cs_edge_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cs_n) |-> (!sclk && !$past(sclk)));

   // R4
   mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));

   // R4
   mosi_hold_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> $stable(mosi));

   // R4
   high_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> (hi_run == 16'(HALF_CYC)));

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(short_flags) && $stable(open_flags)));

endmodule

bind drvdiag_seq drvdiag_chk #(.N_CH(N_CH), .HALF_CYC(HALF_CYC)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs_n        (cs_n),
   .sclk        (sclk),
   .mosi        (mosi),
   .done        (done),
   .short_flags (short_flags),
   .open_flags  (open_flags)
);

// File: tb/tb_drvdiag_seq.sv
module tb_drvdiag_seq;

   localparam int N      = 8;
   localparam int HALF   = 2;
   localparam int LEAD   = 3;
   localparam int LAG    = 3;
   localparam int SETTLE = 20;
   localparam longint PER = 20;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [N-1:0] ctrl_byte = '0;
   logic         cs_n, sclk, mosi, miso, done;
   logic [N-1:0] short_flags, open_flags;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   drvdiag_seq #(.N_CH(N), .HALF_CYC(HALF), .LEAD_CYC(LEAD), .LAG_CYC(LAG),
                 .SETTLE_CYC(SETTLE)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .ctrl_byte(ctrl_byte),
      .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso), .done(done),
      .short_flags(short_flags), .open_flags(open_flags)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // behavioural driver model
   logic [N-1:0] flt_short = '0, flt_open = '0;
   logic [N-1:0] dev_sr = '0, dev_latch = '1;

   function automatic logic [N-1:0] sense(input logic [N-1:0] lat);
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) r[i] = lat[i] ? ~flt_open[i] : flt_short[i];
      return r;
   endfunction

   assign miso = dev_sr[N-1];

   // frame monitor
   bit           mon_en = 1'b0;
   int           frames = 0;
   int           rises = 0;
   logic [N-1:0] si_byte = '0;
   logic [N-1:0] exp_ctrl = '0;
   longint       t_cs_fall = 0, t_cs_rise = 0, t_rise = 0, t_fall = 0;

   always @(negedge cs_n) begin
      dev_sr <= sense(dev_latch);
      if (mon_en) begin
         chk(sclk == 1'b0, "R3", "sclk at cs fall", sclk, 0);
         if (frames == 1)
            chk(($time - t_cs_rise) == SETTLE * PER, "R2", "settle gap ns",
                $time - t_cs_rise, SETTLE * PER);
      end
      t_cs_fall = $time;
      rises = 0;
      si_byte = '0;
   end

   always @(posedge cs_n) begin
      dev_latch <= dev_sr;
      if (mon_en && frames < 2) begin
         chk(sclk == 1'b0, "R3", "sclk at cs rise", sclk, 0);
         chk(rises == N, "R1", "sclk pulses per frame", rises, N);
         chk(si_byte == exp_ctrl, "R1", "byte on mosi", si_byte, exp_ctrl);
         chk(($time - t_fall) == (HALF + LAG) * PER, "R5", "lag ns",
             $time - t_fall, (HALF + LAG) * PER);
         frames++;
      end
      t_cs_rise = $time;
   end

   always @(posedge sclk) begin
      if (mon_en) begin
         chk(!cs_n, "R3", "sclk toggles inside frame", cs_n, 0);
         if (rises == 0)
            chk(($time - t_cs_fall) == LEAD * PER, "R5", "lead ns",
                $time - t_cs_fall, LEAD * PER);
         else
            chk(($time - t_fall) == HALF * PER, "R4", "low phase ns",
                $time - t_fall, HALF * PER);
      end
      rises++;
      t_rise = $time;
   end

   always @(negedge sclk) begin
      if (!cs_n) dev_sr <= {dev_sr[N-2:0], mosi};
      si_byte = {si_byte[N-2:0], mosi};
      if (mon_en)
         chk(($time - t_rise) == HALF * PER, "R4", "high phase ns",
             $time - t_rise, HALF * PER);
      t_fall = $time;
   end

   task automatic run(input logic [N-1:0] c, input logic [N-1:0] s,
                      input logic [N-1:0] o, input bit poke);
      logic [N-1:0] ret, sf, of;
      int wait_cyc;
      flt_short = s;
      flt_open  = o;
      exp_ctrl  = c;
      frames    = 0;
      @(negedge clk);
      start = 1'b1;
      ctrl_byte = c;
      @(negedge clk);
      start = 1'b0;
      ctrl_byte = ~c;
      wait_cyc = 0;
      if (poke) begin
         repeat (30) @(negedge clk);
         start = 1'b1;
         ctrl_byte = c ^ 8'h5A;
         @(negedge clk);
         start = 1'b0;
         wait_cyc = 31;
      end
      while (!done && wait_cyc < 1000) begin
         @(negedge clk);
         wait_cyc++;
      end
      ret = sense(c);
      chk(done, "R10", "done pulse seen", done, 1);
      chk(frames == 2, "R1", "frames per run", frames, 2);
      // R6/R7: short = written 0, returned 1
      chk(short_flags == (~c & ret), "R7", "short flags", short_flags, ~c & ret);
      chk(short_flags == (~c & s), "R6", "short flags vs fault mask", short_flags, ~c & s);
      // R8: open = written 1, returned 0
      chk(open_flags == (c & ~ret), "R8", "open flags", open_flags, c & ~ret);
      chk(((short_flags | open_flags) & ~(c ^ ret)) == 0, "R9", "no flag on match",
          (short_flags | open_flags) & ~(c ^ ret), 0);
      sf = short_flags;
      of = open_flags;
      @(negedge clk);
      chk(!done, "R10", "done one cycle", done, 0);
      repeat (2) @(negedge clk);
      chk(short_flags == sf && open_flags == of, "R10", "flags held",
          {short_flags, open_flags}, {sf, of});
   endtask

   initial begin
      #(190000 * PER);
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(cs_n == 1'b1, "R11", "cs_n in reset", cs_n, 1);
      chk(sclk == 1'b0, "R11", "sclk in reset", sclk, 0);
      chk(done == 1'b0, "R11", "done in reset", done, 0);
      chk(short_flags == '0 && open_flags == '0, "R11", "flags in reset",
          {short_flags, open_flags}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      mon_en = 1'b1;
      for (int c = 0; c < 256; c++) begin
         run(8'(c), 8'(c * 37 + 11), 8'(c * 91 + 5), (c % 64) == 7);
      end
      for (int c = 0; c < 256; c++) begin
         run(8'(c), ~8'(c * 53 + 3), ~8'(c * 29 + 17), (c % 50) == 9);
      end
      // boundaries: all-off with every pin open, all-on with every pin shorted
      run(8'hFF, 8'h00, 8'hFF, 1'b0);
      run(8'h00, 8'hFF, 8'h00, 1'b1);
      run(8'hA5, 8'h00, 8'h00, 1'b0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule